// File: doc/BRIEF.md
# Interrupt Status Register Bank

This block holds the interrupt state of a serial bus controller. Twelve event sources feed a raw status word. Ten of them are one-cycle pulses that the bank latches. The receive-full and transmit-empty sources instead follow level inputs taken from the FIFO thresholds. A mask register selects which sources may raise the single interrupt line. A masked view of the status can be read back.

Software clears events by reading. Each latched source has its own clear address, and a read there clears that source alone. A clear-all address clears every latched source at once. When a transmit abort event fires, the bank captures an abort-cause word. That word stays held until the abort source is cleared.

The register port is plain. It has an address, a read strobe, a write strobe, the write data and combinational read data. There is no valid/ready stream at any edge of this block. Read data is valid in the same cycle as the address. A clear takes effect at the clock edge that ends the strobed read.

Top module: `irq_status_bank`

## Requirements
- R1: Source bit positions from bit 0 are:
  - bit 0: rx underflow
  - bit 1: rx overflow
  - bit 2: rx full
  - bit 3: tx overflow
  - bit 4: tx empty
  - bit 5: read request
  - bit 6: tx abort
  - bit 7: rx done
  - bit 8: activity
  - bit 9: stop detected
  - bit 10: start detected
  - bit 11: general call

  A pulse on a latched source sets its raw bit from the next cycle. The bit stays set until it is cleared. The raw status reads at address 0.
- R2: The masked status at address 2 equals the raw status ANDed with the mask.
- R3: The mask register is at address 1 and resets to 0x254, which enables rx full, tx empty, tx abort and stop detected. A write there loads bits 11:0 from the next cycle. A write to any other address has no effect.
- R4: A strobed read of address 8+i clears raw bit i only. That read returns the old bit i in bit 0.
- R5: A strobed read of address 4 returns the raw status and clears every latched source. It also clears the abort-cause word.
- R6: A tx-abort pulse ORs the abort-cause input into the cause word at address 3. A strobed read of address 14, the tx-abort clear, zeroes the cause word.
- R7: An event pulse in the same cycle as a clear of its bit wins, so the bit stays set. For the cause word, a capture in the clearing cycle loads the new cause alone.
- R8: The irq output is high exactly when any masked status bit is set.
- R9: Raw bits 2 and 4 follow their level inputs, ORed with any pulse on their event bit in that cycle. Clears have no effect on them.
- R10: Without the read strobe, no address changes any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_rd_i | input | 1 | Read strobe; enables clear-on-read |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | NUM_SRC | Write data (mask field) |
| reg_rdata_o | output | RD_W | Combinational read data |
| evt_i | input | NUM_SRC | Event pulses, one per source |
| lvl_rx_full_i | input | 1 | Receive threshold level |
| lvl_tx_empty_i | input | 1 | Transmit threshold level |
| abort_cause_i | input | CAUSE_W | Abort cause presented with the tx-abort pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume that the inputs are stable at the clock edge and that reset is held for at least one edge at start-up. They also assume that a clear read without a coincident event of the same bit is the only way to lower a latched bit. The stimulus drives every input half a cycle away from the sampling edge. It keeps event pulses sparse, so that set, clear and hold all occur often. It also places a few coincident event-and-clear cycles and unstrobed accesses to clear addresses on purpose.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int SRC_RX_UNDER  = 0;
  localparam int SRC_RX_OVER   = 1;
  localparam int SRC_RX_FULL   = 2;
  localparam int SRC_TX_OVER   = 3;
  localparam int SRC_TX_EMPTY  = 4;
  localparam int SRC_RD_REQ    = 5;
  localparam int SRC_TX_ABRT   = 6;
  localparam int SRC_RX_DONE   = 7;
  localparam int SRC_ACTIVITY  = 8;
  localparam int SRC_STOP      = 9;
  localparam int SRC_START     = 10;
  localparam int SRC_GEN_CALL  = 11;

  localparam logic [11:0] MASK_RESET = 12'h254;

  localparam int REG_RAW     = 0;
  localparam int REG_MASK    = 1;
  localparam int REG_MASKED  = 2;
  localparam int REG_CAUSE   = 3;
  localparam int REG_CLR_ALL = 4;

  function automatic bit is_level_src(int idx);
    return (idx == SRC_RX_FULL) || (idx == SRC_TX_EMPTY);
  endfunction
endpackage

// File: rtl/irq_latch_bit.sv
module irq_latch_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic bit_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     bit_o <= 1'b0;
    else if (set_i) bit_o <= 1'b1;   // set beats clear
    else if (clr_i) bit_o <= 1'b0;
  end
endmodule

// File: rtl/irq_clr_decode.sv
module irq_clr_decode
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC  = 12,
  parameter int ADDR_W   = 5,
  parameter int CLR_BASE = 8
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rd_i,
  output logic [NUM_SRC-1:0] clr_o,
  output logic               cause_clr_o
);
  logic hit_all;
  assign hit_all = (addr_i == ADDR_W'(REG_CLR_ALL));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign clr_o[i] = rd_i && (hit_all || (addr_i == ADDR_W'(CLR_BASE + i)));
  end

  assign cause_clr_o = clr_o[SRC_TX_ABRT];
endmodule

// File: rtl/irq_abort_cause.sv
module irq_abort_cause #(
  parameter int CAUSE_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture_i,
  input  logic               clear_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [CAUSE_W-1:0] cause_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_o <= '0;
    end else if (clear_i) begin
      cause_o <= capture_i ? cause_i : '0;
    end else if (capture_i) begin
      cause_o <= cause_o | cause_i;
    end
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC  = 12,
  parameter int ADDR_W   = 5,
  parameter int CAUSE_W  = 13,
  parameter int RD_W     = 16,
  parameter int CLR_BASE = 8
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] raw_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [RD_W-1:0]    rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(REG_RAW) || addr_i == ADDR_W'(REG_CLR_ALL))
      rdata_o = RD_W'(raw_i);
    else if (addr_i == ADDR_W'(REG_MASK))
      rdata_o = RD_W'(mask_i);
    else if (addr_i == ADDR_W'(REG_MASKED))
      rdata_o = RD_W'(raw_i & mask_i);
    else if (addr_i == ADDR_W'(REG_CAUSE))
      rdata_o = RD_W'(cause_i);
    else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (addr_i == ADDR_W'(CLR_BASE + i)) rdata_o = RD_W'(raw_i[i]);
      end
    end
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC  = 12,
  parameter int ADDR_W   = 5,
  parameter int CAUSE_W  = 13,
  parameter int RD_W     = 16,
  parameter int CLR_BASE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_rd_i,
  input  logic               reg_wr_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [RD_W-1:0]    reg_rdata_o,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               lvl_rx_full_i,
  input  logic               lvl_tx_empty_i,
  input  logic [CAUSE_W-1:0] abort_cause_i,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] clr_vec;
  logic               cause_clr;
  logic [NUM_SRC-1:0] raw_bits;
  logic [NUM_SRC-1:0] mask_q;
  logic [CAUSE_W-1:0] cause_q;

  irq_clr_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .CLR_BASE(CLR_BASE)) u_dec (
    .addr_i      (reg_addr_i),
    .rd_i        (reg_rd_i),
    .clr_o       (clr_vec),
    .cause_clr_o (cause_clr)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i == SRC_RX_FULL) begin : g_lvl_rx
      assign raw_bits[i] = lvl_rx_full_i | evt_i[i];
    end else if (i == SRC_TX_EMPTY) begin : g_lvl_tx
      assign raw_bits[i] = lvl_tx_empty_i | evt_i[i];
    end else begin : g_lat
      irq_latch_bit u_bit (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_i[i]),
        .clr_i (clr_vec[i]),
        .bit_o (raw_bits[i])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mask_q <= NUM_SRC'(MASK_RESET);
    else if (reg_wr_i && reg_addr_i == ADDR_W'(REG_MASK))
      mask_q <= reg_wdata_i;
  end

  irq_abort_cause #(.CAUSE_W(CAUSE_W)) u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (evt_i[SRC_TX_ABRT]),
    .clear_i   (cause_clr),
    .cause_i   (abort_cause_i),
    .cause_o   (cause_q)
  );

  irq_read_mux #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W),
                 .RD_W(RD_W), .CLR_BASE(CLR_BASE)) u_rd (
    .addr_i  (reg_addr_i),
    .raw_i   (raw_bits),
    .mask_i  (mask_q),
    .cause_i (cause_q),
    .rdata_o (reg_rdata_o)
  );

  assign irq_o = |(raw_bits & mask_q);
endmodule

// File: rtl/irq_status_bank_chk.sv
module irq_status_bank_chk
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC  = 12,
  parameter int ADDR_W   = 5,
  parameter int CAUSE_W  = 13,
  parameter int RD_W     = 16,
  parameter int CLR_BASE = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic               reg_rd_i,
  input logic               reg_wr_i,
  input logic [NUM_SRC-1:0] reg_wdata_i,
  input logic [RD_W-1:0]    reg_rdata_o,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               lvl_rx_full_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] raw_bits,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [CAUSE_W-1:0] cause_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (!is_level_src(i)) begin : g_lat
      // R7: a set in the clearing cycle keeps the bit
      a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[i] |=> raw_bits[i]);
      // R4: own clear address lowers the bit
      a_r4_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == ADDR_W'(CLR_BASE + i) && !evt_i[i]) |=> !raw_bits[i]);
      // R10: nothing moves without the read strobe or an event
      a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd_i && !evt_i[i]) |=> $stable(raw_bits[i]));
    end
  end

  // R3
  a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == ADDR_W'(REG_MASK)) |=> mask_q == $past(reg_wdata_i));
  a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_addr_i == ADDR_W'(REG_MASK)) |=> $stable(mask_q));

  // R6 / R5: cause wiped by its clear unless recaptured
  a_r6_cause_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && !evt_i[SRC_TX_ABRT] &&
     (reg_addr_i == ADDR_W'(CLR_BASE + SRC_TX_ABRT) || reg_addr_i == ADDR_W'(REG_CLR_ALL)))
    |=> cause_q == '0);

  // R8: irq agrees with the masked view on the read port
  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ADDR_W'(REG_MASKED)) |-> irq_o == (|reg_rdata_o[NUM_SRC-1:0]));

  // R9: level source shows its input on the raw view
  a_r9_level_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ADDR_W'(REG_RAW) && !evt_i[SRC_RX_FULL])
    |-> reg_rdata_o[SRC_RX_FULL] == lvl_rx_full_i);
endmodule

bind irq_status_bank irq_status_bank_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .RD_W(RD_W), .CLR_BASE(CLR_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr_i), .reg_rd_i(reg_rd_i),
  .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .evt_i(evt_i), .lvl_rx_full_i(lvl_rx_full_i), .irq_o(irq_o),
  .raw_bits(raw_bits), .mask_q(mask_q), .cause_q(cause_q)
);

// File: tb/irq_status_bank_tb_top.sv
`timescale 1ns/1ps
module irq_status_bank_tb_top;
  localparam int NS = 12, AW = 5, CW = 13, RW = 16, CB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rd = 1'b0, wr = 1'b0;
  logic [NS-1:0] wdata = '0, evt = '0;
  logic          lrx = 1'b0, ltx = 1'b0;
  logic [CW-1:0] cause_in = '0;
  logic [RW-1:0] rdata;
  logic          irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [NS-1:0] m_lat, m_mask;
  logic [CW-1:0] m_cause;

  always #2.5 clk = ~clk;

  irq_status_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt),
    .lvl_rx_full_i(lrx), .lvl_tx_empty_i(ltx), .abort_cause_i(cause_in), .irq_o(irq)
  );

  function automatic logic [NS-1:0] exp_raw();
    logic [NS-1:0] r = m_lat;
    r[2] = lrx | evt[2];
    r[4] = ltx | evt[4];
    return r;
  endfunction

  function automatic logic [RW-1:0] exp_rdata(input logic [AW-1:0] a);
    logic [NS-1:0] r = exp_raw();
    if (a == 0 || a == 4) return RW'(r);
    if (a == 1) return RW'(m_mask);
    if (a == 2) return RW'(r & m_mask);
    if (a == 3) return RW'(m_cause);
    if (a >= CB && a < CB + NS) return RW'(r[a - CB]);
    return '0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // one cycle: drive at negedge, check the combinational view, then advance the model
  task automatic cyc(input logic [AW-1:0] a, input logic r, input logic w,
                     input logic [NS-1:0] wd, input logic [NS-1:0] ev,
                     input logic [CW-1:0] ci, input string tag);
    logic [NS-1:0] clr;
    @(negedge clk);
    addr = a; rd = r; wr = w; wdata = wd; evt = ev; cause_in = ci;
    #1;
    check(tag, 32'(rdata), 32'(exp_rdata(a)));
    check("R8 irq", 32'(irq), 32'(|(exp_raw() & m_mask)));
    @(posedge clk);
    clr = '0;
    if (r && a == 4) clr = '1;
    else if (r && a >= CB && a < CB + NS) clr[a - CB] = 1'b1;
    m_lat = ((m_lat & ~clr) | ev) & 12'hFEB;
    if (r && (a == 4 || a == CB + 6)) m_cause = ev[6] ? ci : '0;
    else if (ev[6]) m_cause = m_cause | ci;
    if (w && a == 1) m_mask = wd;
  endtask

  function automatic string tag_of(input logic [AW-1:0] a);
    case (a)
      0: return "R1 raw";
      1: return "R3 mask";
      2: return "R2 masked";
      3: return "R6 cause";
      4: return "R5 clear-all";
      default: return "R4 per-source";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_lat = '0; m_mask = 12'h254; m_cause = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // reset state
    cyc(1, 0, 0, '0, '0, '0, "R3 reset mask");
    cyc(0, 0, 0, '0, '0, '0, "R1 reset raw");
    // latching and bit order
    cyc(0, 0, 0, '0, 12'h801, '0, "R1 pulse cycle");
    cyc(0, 0, 0, '0, '0, '0, "R1 bits 0 and 11 latched");
    // per-source clear of bit 0 only
    cyc(CB, 1, 0, '0, '0, '0, "R4 clear bit0 read");
    cyc(0, 0, 0, '0, '0, '0, "R4 bit11 kept");
    // coincident event and clear
    cyc(CB + 11, 1, 0, '0, 12'h800, '0, "R7 clear with event");
    cyc(0, 0, 0, '0, '0, '0, "R7 bit stays");
    // unstrobed access to clear address
    cyc(CB + 11, 0, 0, '0, '0, '0, "R10 no strobe");
    cyc(0, 0, 0, '0, '0, '0, "R10 bit unchanged");
    // write to a non-mask address ignored
    cyc(2, 0, 1, 12'h000, '0, '0, "R3 stray write");
    cyc(1, 0, 0, '0, '0, '0, "R3 mask unchanged");
    // abort cause accumulation and wipe
    cyc(3, 0, 0, '0, 12'h040, 13'h005, "R6 capture");
    cyc(3, 0, 0, '0, 12'h040, 13'h100, "R6 accumulate");
    cyc(3, 0, 0, '0, '0, '0, "R6 cause held");
    cyc(CB + 6, 1, 0, '0, '0, '0, "R6 abort clear");
    cyc(3, 0, 0, '0, '0, '0, "R6 cause wiped");
    // levels and clear-all
    lrx = 1'b1; ltx = 1'b1;
    cyc(0, 0, 0, '0, 12'h3A3, 13'h0FF, "R9 levels shown");
    cyc(4, 1, 0, '0, '0, '0, "R5 clear-all read");
    cyc(0, 0, 0, '0, '0, '0, "R9 levels survive clear-all");
    cyc(3, 0, 0, '0, '0, '0, "R5 cause cleared");
    cyc(CB + 2, 1, 0, '0, '0, '0, "R9 clear level ignored");
    cyc(0, 0, 0, '0, '0, '0, "R9 still level");
    lrx = 1'b0; ltx = 1'b0;
    // mask update and masked view
    cyc(1, 0, 1, 12'h001, '0, '0, "R3 mask write");
    cyc(1, 0, 0, '0, 12'h001, '0, "R3 mask readback");
    cyc(2, 0, 0, '0, '0, '0, "R2 masked view");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] a;
      int sel = $urandom % 20;
      a = (sel >= 5 && sel <= 7) ? AW'(2) : AW'(sel);
      lrx = ($urandom % 4) == 0;
      ltx = ($urandom % 4) == 0;
      cyc(a, ($urandom % 3) == 0, (a == 1) && (($urandom % 3) == 0),
          NS'($urandom), NS'($urandom & $urandom & $urandom),
          CW'($urandom), tag_of(a));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule